// File: doc/BRIEF.md
# Shared Target Bus Arbiter for Three Masters

This block decides which of three masters owns a single shared target bus. The three masters are a host processor, a coprocessor and a debug master. Each master raises a request, receives a grant, and ends its access with a done pulse. The coprocessor also has a qualifier input. That input marks a request as an access to a privileged register region.

Ownership is decided only at operation boundaries. A boundary is a cycle in which the bus is idle, or in which the current owner pulses done or drops its request. At a boundary the priority order, highest first, is:

1. A privileged-region coprocessor request.
2. An escalated debug request.
3. The host.
4. An ordinary coprocessor request.
5. An ordinary debug request.

A saturating wait counter tracks how long the debug master has been kept waiting. Once it has waited long enough, the debug request is escalated so that it beats the other two masters. The current owner is never cut off in the middle of an access.

Top module: `tbus_arbiter`

## Requirements
- R1: The grant vector is one-hot or all zero in every cycle. Bit 0 is the host, bit 1 is the coprocessor and bit 2 is the debug master.
- R2: While reset (synchronous, active high) is applied, the grant becomes all zero and the wait counter clears.
- R3: At a boundary with no privileged request and no escalation, a host request wins over the coprocessor and debug requests.
- R4: At a boundary where the host does not request, a coprocessor request wins over a debug request.
- R5: A privileged-region coprocessor request wins every boundary. The host stays stalled for the whole coprocessor access.
- R6: A grant stays with its owner until that owner pulses done or drops its request. The newly chosen grant appears in the cycle after the boundary.
- R7: The wait counter advances in each cycle in which the debug request is high and not granted. Once it exceeds 128, the debug master wins at the next boundary.
- R8: Escalation never removes a grant between boundaries. The owner finishes its access first.
- R9: When a privileged coprocessor request and an escalated debug request meet at a boundary, the coprocessor is served first. The debug master follows at the next boundary with its escalation still in force.
- R10: For each master, its stall output is high exactly when it requests and does not hold the grant.
- R11: When the debug request drops for one cycle, the wait counter clears. A new request must then wait more than 128 ungranted cycles before it escalates again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Host requests the bus |
| host_done | input | 1 | Host ends its current access |
| copro_req | input | 1 | Coprocessor requests the bus |
| copro_priv | input | 1 | Coprocessor request targets the privileged register region |
| copro_done | input | 1 | Coprocessor ends its current access |
| dbg_req | input | 1 | Debug master requests the bus |
| dbg_done | input | 1 | Debug master ends its current access |
| grant | output | 3 | One-hot grant: bit 0 host, bit 1 coprocessor, bit 2 debug |
| stall | output | 3 | Per-master stall, same bit order as grant |

## Verification
The bench uses several request patterns, and each one isolates a different part of the priority logic.

- **All three request together, released one by one.** This pattern separates the fixed order (R3, R4) from the hold-until-done rule (R6).
- **Privileged request colliding with a host request.** This shows the override (R5).
- **Host re-winning with periodic done pulses while debug waits.** This shows the escalation threshold (R7). It also shows that the hand-over happens only on a done boundary (R8).
- **Debug request dropped for one cycle.** This shows that the wait counter clears (R11).
- **Privileged request arriving exactly when debug is escalated.** This fixes the service order (R9).
- **Random phase checked against a behavioural model every clock.** This covers the interleavings the directed cases miss.

// File: rtl/tbus_pkg.sv
package tbus_pkg;
    localparam int NUM_MASTERS = 3;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_HOST  = 2'd1,
        OWN_COPRO = 2'd2,
        OWN_DBG   = 2'd3
    } owner_e;

    typedef struct packed {
        owner_e owner;
    } arb_state_t;
endpackage

// File: rtl/tbus_starve_ctr.sv
module tbus_starve_ctr #(
    parameter int CNT_W = 8,
    parameter int LIMIT = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic waiting,
    output logic escalate
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (waiting) begin
            cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign escalate = (cnt_q > CNT_LIM);
endmodule

// File: rtl/tbus_prio_pick.sv
module tbus_prio_pick
    import tbus_pkg::*;
(
    input  logic   host_req,
    input  logic   copro_req,
    input  logic   copro_priv,
    input  logic   dbg_req,
    input  logic   dbg_esc,
    output owner_e pick
);
    always_comb begin
        if (copro_req && copro_priv) pick = OWN_COPRO;
        else if (dbg_req && dbg_esc) pick = OWN_DBG;
        else if (host_req)           pick = OWN_HOST;
        else if (copro_req)          pick = OWN_COPRO;
        else if (dbg_req)            pick = OWN_DBG;
        else                         pick = OWN_NONE;
    end
endmodule

// File: rtl/tbus_arbiter.sv
module tbus_arbiter
    import tbus_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int LIMIT = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_req,
    input  logic       host_done,
    input  logic       copro_req,
    input  logic       copro_priv,
    input  logic       copro_done,
    input  logic       dbg_req,
    input  logic       dbg_done,
    output logic [2:0] grant,
    output logic [2:0] stall
);
    arb_state_t state_d, state_q;
    owner_e     pick;
    logic       dbg_esc;
    logic       owner_done;
    logic       owner_req;
    logic       boundary;
    logic [NUM_MASTERS-1:0] req_vec;

    assign req_vec = {dbg_req, copro_req, host_req};

    tbus_starve_ctr #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_starve (
        .clk      (clk),
        .rst      (rst),
        .waiting  (dbg_req && !grant[2]),
        .escalate (dbg_esc)
    );

    tbus_prio_pick u_pick (
        .host_req   (host_req),
        .copro_req  (copro_req),
        .copro_priv (copro_priv),
        .dbg_req    (dbg_req),
        .dbg_esc    (dbg_esc),
        .pick       (pick)
    );

    always_comb begin
        grant      = '0;
        owner_done = 1'b0;
        owner_req  = 1'b0;
        case (state_q.owner)
            OWN_HOST:  begin grant[0] = 1'b1; owner_done = host_done;  owner_req = host_req;  end
            OWN_COPRO: begin grant[1] = 1'b1; owner_done = copro_done; owner_req = copro_req; end
            OWN_DBG:   begin grant[2] = 1'b1; owner_done = dbg_done;   owner_req = dbg_req;   end
            default:   ;
        endcase
        boundary = (state_q.owner == OWN_NONE) || owner_done || !owner_req;
        state_d  = state_q;
        if (boundary) state_d.owner = pick;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '{owner: OWN_NONE};
        else     state_q <= state_d;
    end

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_stall
        assign stall[m] = req_vec[m] && !grant[m];
    end
endmodule

// File: rtl/tbus_arbiter_chk.sv
module tbus_arbiter_chk (
    input logic       clk,
    input logic       rst,
    input logic       host_req,
    input logic       host_done,
    input logic       copro_req,
    input logic       copro_priv,
    input logic       copro_done,
    input logic       dbg_req,
    input logic       dbg_done,
    input logic [2:0] grant
);
    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (grant == 3'b000));

    // R3
    host_first_chk: assert property (@(posedge clk) disable iff (rst)
        (grant == 3'b000 && host_req && !dbg_req && !(copro_req && copro_priv)) |=> grant[0]);

    // R5
    priv_override_chk: assert property (@(posedge clk) disable iff (rst)
        (grant == 3'b000 && copro_req && copro_priv) |=> grant[1]);

    // R6
    host_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (grant[0] && host_req && !host_done) |=> grant[0]);

    // R8
    copro_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (grant[1] && copro_req && !copro_done) |=> grant[1]);

    // R6
    dbg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (grant[2] && dbg_req && !dbg_done) |=> grant[2]);
endmodule

bind tbus_arbiter tbus_arbiter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_req   (host_req),
    .host_done  (host_done),
    .copro_req  (copro_req),
    .copro_priv (copro_priv),
    .copro_done (copro_done),
    .dbg_req    (dbg_req),
    .dbg_done   (dbg_done),
    .grant      (grant)
);

// File: tb/tbus_arbiter_test.sv
`timescale 1ns/100ps
module tbus_arbiter_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hreq = 0, hdone = 0, creq = 0, cpriv = 0, cdone = 0, dreq = 0, ddone = 0;
    logic [2:0] grant, stall;

    int checks = 0;
    int fails  = 0;

    int m_owner = 0;
    int m_cnt   = 0;

    always #2.5 clk = ~clk;

    tbus_arbiter uut (
        .clk(clk), .rst(rst),
        .host_req(hreq), .host_done(hdone),
        .copro_req(creq), .copro_priv(cpriv), .copro_done(cdone),
        .dbg_req(dreq), .dbg_done(ddone),
        .grant(grant), .stall(stall)
    );

    function automatic logic [2:0] owner_vec(int o);
        return (o == 0) ? 3'b000 : 3'(1 << (o - 1));
    endfunction

    // Behavioural reference: who owns the bus, how long debug has waited.
    always @(posedge clk) begin
        if (rst) begin
            m_owner = 0;
            m_cnt   = 0;
        end else begin
            bit free;
            bit esc;
            int next_cnt;
            free = (m_owner == 0) ||
                   (m_owner == 1 && (hdone || !hreq)) ||
                   (m_owner == 2 && (cdone || !creq)) ||
                   (m_owner == 3 && (ddone || !dreq));
            esc = (m_cnt > 128);
            next_cnt = (dreq && m_owner != 3) ? ((m_cnt >= 255) ? 255 : m_cnt + 1) : 0;
            if (free) begin
                if (creq && cpriv)     m_owner = 2;
                else if (dreq && esc)  m_owner = 3;
                else if (hreq)         m_owner = 1;
                else if (creq)         m_owner = 2;
                else if (dreq)         m_owner = 3;
                else                   m_owner = 0;
            end
            m_cnt = next_cnt;
        end
    end

    // Per-clock comparison against the reference.
    always @(posedge clk) begin
        #1;
        begin
            logic [2:0] eg;
            logic [2:0] es;
            eg = owner_vec(m_owner);
            es = {dreq, creq, hreq} & ~eg;
            checks++;
            if (grant !== eg) begin
                fails++;
                $display("FAIL R1 grant vs model at %0t: act=%b exp=%b", $time, grant, eg);
            end
            checks++;
            if (stall !== es) begin
                fails++;
                $display("FAIL R10 stall vs model at %0t: act=%b exp=%b", $time, stall, es);
            end
        end
    end

    task automatic expect_grant(string tag, logic [2:0] exp);
        checks++;
        if (grant !== exp) begin
            fails++;
            $display("FAIL %s grant act=%b exp=%b", tag, grant, exp);
        end
    endtask

    task automatic expect_stall(string tag, logic [2:0] exp);
        checks++;
        if (stall !== exp) begin
            fails++;
            $display("FAIL %s stall act=%b exp=%b", tag, stall, exp);
        end
    endtask

    // Drive at the falling edge, observe 1 ns after the next rising edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive_pt();
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        hreq = 0; hdone = 0; creq = 0; cpriv = 0; cdone = 0; dreq = 0; ddone = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit dbg_seen;
        bit prev_hdone;
        bit cut_ok;

        // R2: reset clears grant
        hreq = 1; creq = 1; dreq = 1;
        repeat (3) step();
        expect_grant("R2", 3'b000);
        drive_pt(); rst = 0; clear_inputs();
        step();

        // R3: all three request, host wins
        drive_pt(); hreq = 1; creq = 1; dreq = 1;
        step();
        expect_grant("R3", 3'b001);
        expect_stall("R10", 3'b110);

        // R6: grant held while the host has not finished
        drive_pt(); step(); step();
        expect_grant("R6", 3'b001);

        // R4: host finishes and leaves, coprocessor beats debug
        drive_pt(); hdone = 1;
        step();
        expect_grant("R6", 3'b001);
        drive_pt(); hdone = 0; hreq = 0;
        step();
        expect_grant("R4", 3'b010);
        drive_pt(); cdone = 1;
        step();
        drive_pt(); cdone = 0; creq = 0;
        step();
        expect_grant("R4", 3'b100);
        drive_pt(); ddone = 1; dreq = 0;
        step();
        drive_pt(); ddone = 0;
        step();
        expect_grant("R6", 3'b000);

        // R5: privileged coprocessor request overrides the host
        drive_pt(); hreq = 1; creq = 1; cpriv = 1;
        step();
        expect_grant("R5", 3'b010);
        expect_stall("R5", 3'b001);
        drive_pt(); step(); step();
        expect_grant("R5", 3'b010);
        expect_stall("R5", 3'b001);
        drive_pt(); cdone = 1; creq = 0; cpriv = 0;
        step();
        expect_grant("R5", 3'b001);
        drive_pt(); cdone = 0; hdone = 1; hreq = 0;
        step();
        drive_pt(); clear_inputs();
        step();

        // R7 / R8: host re-wins on every done pulse until debug escalates
        dbg_seen = 0;
        prev_hdone = 0;
        cut_ok = 1;
        drive_pt(); hreq = 1; dreq = 1;
        for (int i = 0; i < 200 && !dbg_seen; i++) begin
            drive_pt();
            prev_hdone = hdone;
            hdone = (i % 4 == 3);
            step();
            if (grant[2]) begin
                dbg_seen = 1;
                checks++;
                if (i < 129) begin
                    fails++;
                    $display("FAIL R7 debug granted early act=%0d exp>=129", i);
                end
                if (!hdone) cut_ok = 0;
            end
        end
        checks++;
        if (!dbg_seen) begin
            fails++;
            $display("FAIL R7 debug never escalated act=0 exp=1");
        end
        checks++;
        if (!cut_ok) begin
            fails++;
            $display("FAIL R8 host cut off mid-access act=0 exp=1");
        end
        drive_pt(); hdone = 0; hreq = 0; ddone = 1; dreq = 0;
        step();
        drive_pt(); clear_inputs();
        step();

        // R11: a one-cycle drop of the debug request restarts the wait
        drive_pt(); hreq = 1; dreq = 1;
        repeat (100) step();
        drive_pt(); dreq = 0;
        step();
        dbg_seen = 0;
        drive_pt(); dreq = 1;
        for (int i = 0; i < 60; i++) begin
            drive_pt();
            hdone = (i % 4 == 3);
            step();
            if (grant[2]) dbg_seen = 1;
        end
        checks++;
        if (dbg_seen) begin
            fails++;
            $display("FAIL R11 debug escalated after drop act=1 exp=0");
        end
        drive_pt(); clear_inputs(); hdone = 1;
        step();
        drive_pt(); clear_inputs();
        step();

        // R9: privileged request and escalated debug meet at one boundary
        drive_pt(); hreq = 1; dreq = 1;
        repeat (140) step();
        expect_grant("R9", 3'b001);
        drive_pt(); hdone = 1; hreq = 0; creq = 1; cpriv = 1;
        step();
        expect_grant("R9", 3'b010);
        drive_pt(); hdone = 0; cdone = 1; creq = 0; cpriv = 0;
        step();
        expect_grant("R9", 3'b100);
        drive_pt(); clear_inputs(); ddone = 1;
        step();
        drive_pt(); clear_inputs();
        step();

        // Random phase, checked against the reference every clock
        for (int i = 0; i < 600; i++) begin
            drive_pt();
            hreq  = ($urandom_range(0, 3) != 0);
            hdone = ($urandom_range(0, 3) == 0);
            creq  = ($urandom_range(0, 2) == 0);
            cpriv = ($urandom_range(0, 4) == 0);
            cdone = ($urandom_range(0, 2) == 0);
            dreq  = ($urandom_range(0, 1) == 0);
            ddone = ($urandom_range(0, 2) == 0);
            step();
        end

        // R2: reset mid-traffic clears the grant
        drive_pt(); rst = 1;
        step();
        expect_grant("R2", 3'b000);
        drive_pt(); rst = 0; clear_inputs();
        step();

        finish_run();
    end
endmodule